// File: doc/BRIEF.md
# Fast-Page DRAM Strobe Cycle Decoder

This block is the device-side control logic of a fast-page-mode DRAM with two byte-lane column strobes. It oversamples the active-low strobes (row strobe, one column strobe per byte lane, write enable, output enable) on a fast system clock and classifies each memory cycle. The classes are standby, read, early write, late write, row-only refresh, strobe-before-row refresh and hidden refresh. It latches row and column addresses on the detected edges and issues per-lane read and write pulses for the storage array. It also drives a per-lane output-enable level for the data pads.

Every strobe and the address bus pass through a synchroniser of `SYNC_STAGES` flip-flops. Edge detection then compares the synchronised sample with the one before it. A registered output reflects an input change on the third rising clock edge after that change. Refresh cycles that carry no row address take their row from an internal counter that advances after each such refresh.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, and whenever the row strobe and all lane strobes are high, `cyc_type` is 0 (standby) and `oe_lane` is all zero.
- R2: A row strobe fall with all lane strobes high latches `addr` into `row_addr`. A later first lane fall with write enable high latches `addr` into `col_addr`, sets `cyc_type` to 1 (read) and gives one `rd_stb` pulse on each lane whose strobe fell.
- R3: `oe_lane[i]` is high only while lane i's strobe is low, write enable is high, output enable is low and a read has been made in the current column access. Bit 0 is the lower byte (`cas_n[0]`) and bit 1 the upper byte.
- R4: If write enable is already low when a lane strobe falls inside an access, `cyc_type` becomes 2 (early write), that lane gets one `wr_stb` pulse, and `oe_lane` stays zero.
- R5: If write enable falls during a read while lane strobes are held low, `cyc_type` becomes 3 (late write), each low lane gets one `wr_stb` pulse, and `oe_lane` drops to zero.
- R6: With the row strobe held low, each new first lane fall latches a new `col_addr` and makes a new read or write pulse on the same `row_addr`.
- R7: The internal column strobe is active from the first lane fall to the last lane rise. A second lane falling later does not re-latch `col_addr`, and the cycle does not end while any lane is still low.
- R8: A row strobe fall with all lanes high, followed by no lane fall before the row strobe rises, gives `cyc_type` 4 (row-only refresh). At the row strobe rise there is one `ref_stb` pulse with `ref_row` equal to the latched row.
- R9: A row strobe fall while any lane strobe is already low, outside an access, gives `cyc_type` 5 (strobe-before-row refresh). It gives one `ref_stb` with `ref_row` taken from the refresh counter. `row_addr` is left unchanged, and no `rd_stb`, no `wr_stb` and no `oe_lane` occur.
- R10: After an access, a row strobe rise and fall while a lane strobe stays low gives `cyc_type` 6 (hidden refresh). It gives one `ref_stb` from the refresh counter, and the read data enables remain on.
- R11: The refresh counter resets to 0, advances by one after each counter-sourced refresh, and wraps from 2^ADDR_W-1 (511 by default) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Per-lane column strobes, active low, bit 0 = lower byte |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| rd_stb | output | LANES | One-cycle per-lane read pulse |
| wr_stb | output | LANES | One-cycle per-lane write pulse |
| oe_lane | output | LANES | Per-lane data output enable level |
| cyc_type | output | 3 | Cycle class: 0 standby, 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 strobe-before-row refresh, 6 hidden refresh |
| ref_stb | output | 1 | One-cycle refresh pulse |
| ref_row | output | ADDR_W | Row being refreshed, valid with `ref_stb` |

## Verification
A wrong cycle class shows at the ports within three clock edges of the strobe edge that caused it. It appears as a wrong `cyc_type` code, as a read pulse where a write pulse belongs, or as pads left enabled during a refresh. A corrupted refresh counter stays hidden until the next counter-sourced refresh, and then shows as a wrong `ref_row`. The counter wrap can only be seen after a full sweep of rows. A stale edge-history register shows up as a missing or doubled pulse on the next page access.

// File: rtl/dsd_pkg.sv
`timescale 1ns/1ps
package dsd_pkg;

   typedef enum logic [2:0] {
      CT_IDLE   = 3'd0,
      CT_READ   = 3'd1,
      CT_EWR    = 3'd2,
      CT_LWR    = 3'd3,
      CT_RONLY  = 3'd4,
      CT_CBR    = 3'd5,
      CT_HIDDEN = 3'd6
   } cyc_e;

   // cycle classes in which the data path holds a column access
   function automatic logic is_access(input cyc_e t);
      return (t == CT_READ) || (t == CT_EWR) || (t == CT_LWR) || (t == CT_HIDDEN);
   endfunction

endpackage

// File: rtl/dsd_sync.sv
`timescale 1ns/1ps
module dsd_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dsd_refcnt.sv
`timescale 1ns/1ps
module dsd_refcnt #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] LAST = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/dsd_classify.sv
`timescale 1ns/1ps
module dsd_classify
   import dsd_pkg::*;
#(
   parameter int AW = 9,
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras,
   input  logic [LANES-1:0] lane,
   input  logic             we,
   input  logic             oe,
   input  logic [AW-1:0]    addr,
   input  logic [AW-1:0]    ref_cnt,
   output logic             ref_inc,
   output logic [AW-1:0]    row_addr,
   output logic [AW-1:0]    col_addr,
   output logic [LANES-1:0] rd_stb,
   output logic [LANES-1:0] wr_stb,
   output logic [LANES-1:0] oe_lane,
   output cyc_e             cyc,
   output logic             ref_stb,
   output logic [AW-1:0]    ref_row
);
   // previous samples for edge detection
   logic             ras_q, we_q;
   logic [LANES-1:0] lane_q;
   logic             mode_acc, rd_valid;

   logic             cas, cas_q;
   logic             ras_fall, ras_rise, cas_fall, we_fall;
   logic [LANES-1:0] lane_fall;
   logic             cbr_ev, ronly_ev, acc_win;
   logic [LANES-1:0] rd_ev, wr_ev, oe_d;
   cyc_e             cyc_d;

   assign cas       = |lane;
   assign cas_q     = |lane_q;
   assign ras_fall  = ras & ~ras_q;
   assign ras_rise  = ~ras & ras_q;
   assign cas_fall  = cas & ~cas_q;
   assign we_fall   = we & ~we_q;
   assign lane_fall = lane & ~lane_q;

   assign cbr_ev    = ras_fall & cas_q;
   assign ronly_ev  = ras_fall & ~cas_q;
   assign acc_win   = ras & (mode_acc | ronly_ev);

   assign rd_ev = {LANES{acc_win & ~we}} & lane_fall;
   assign wr_ev = {LANES{acc_win}} &
                  ((lane_fall & {LANES{we}}) | (lane & lane_q & {LANES{we_fall}}));
   assign oe_d  = lane & {LANES{~we & oe & (rd_valid | (|rd_ev))}};

   assign ref_inc = cbr_ev;

   always_comb begin
      cyc_d = cyc;
      if (cbr_ev)
         cyc_d = is_access(cyc) ? CT_HIDDEN : CT_CBR;
      else if (acc_win && cas_fall)
         cyc_d = we ? CT_EWR : CT_READ;
      else if (ronly_ev)
         cyc_d = CT_RONLY;
      else if (acc_win && we_fall && cas && cyc == CT_READ)
         cyc_d = CT_LWR;
      else if (!ras && !cas)
         cyc_d = CT_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q    <= 1'b0;
         we_q     <= 1'b0;
         lane_q   <= '0;
         mode_acc <= 1'b0;
         rd_valid <= 1'b0;
         row_addr <= '0;
         col_addr <= '0;
         rd_stb   <= '0;
         wr_stb   <= '0;
         oe_lane  <= '0;
         cyc      <= CT_IDLE;
         ref_stb  <= 1'b0;
         ref_row  <= '0;
      end else begin
         ras_q    <= ras;
         we_q     <= we;
         lane_q   <= lane;
         mode_acc <= ronly_ev | (mode_acc & ras);
         rd_valid <= (|rd_ev) | (rd_valid & cas);
         if (ronly_ev)            row_addr <= addr;
         if (acc_win && cas_fall) col_addr <= addr;
         rd_stb   <= rd_ev;
         wr_stb   <= wr_ev;
         oe_lane  <= oe_d;
         cyc      <= cyc_d;
         ref_stb  <= cbr_ev | (ras_rise & (cyc == CT_RONLY));
         ref_row  <= cbr_ev ? ref_cnt : row_addr;
      end
   end
endmodule

// File: rtl/dram_strobe_decoder.sv
`timescale 1ns/1ps
module dram_strobe_decoder
   import dsd_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int LANES = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic [LANES-1:0]  cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] row_addr,
   output logic [ADDR_W-1:0] col_addr,
   output logic [LANES-1:0]  rd_stb,
   output logic [LANES-1:0]  wr_stb,
   output logic [LANES-1:0]  oe_lane,
   output logic [2:0]        cyc_type,
   output logic              ref_stb,
   output logic [ADDR_W-1:0] ref_row
);
   localparam int STB_W = LANES + 3;
   localparam int RAS_B = LANES;
   localparam int WE_B  = LANES + 1;
   localparam int OE_B  = LANES + 2;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [STB_W-1:0]  stb_s;
   logic [ADDR_W-1:0] addr_s;
   logic [ADDR_W-1:0] ref_cnt;
   logic              ref_inc;
   cyc_e              cyc_w;

   dsd_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) i_sync_stb (
      .clk(clk), .rst_n(rst_n), .d({oe_n, we_n, ras_n, cas_n}), .q(stb_s)
   );

   dsd_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_addr (
      .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s)
   );

   dsd_refcnt #(.W(ADDR_W)) i_refcnt (
      .clk(clk), .rst_n(rst_n), .inc(ref_inc), .cnt(ref_cnt)
   );

   dsd_classify #(.AW(ADDR_W), .LANES(LANES)) i_classify (
      .clk(clk), .rst_n(rst_n),
      .ras(~stb_s[RAS_B]), .lane(~stb_s[LANES-1:0]),
      .we(~stb_s[WE_B]), .oe(~stb_s[OE_B]),
      .addr(addr_s), .ref_cnt(ref_cnt), .ref_inc(ref_inc),
      .row_addr(row_addr), .col_addr(col_addr),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .oe_lane(oe_lane),
      .cyc(cyc_w), .ref_stb(ref_stb), .ref_row(ref_row)
   );

   assign cyc_type = cyc_w;
endmodule

// File: rtl/dram_strobe_decoder_chk.sv
`timescale 1ns/1ps
module dram_strobe_decoder_chk #(
   parameter int AW = 9,
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LANES-1:0] rd_stb,
   input logic [LANES-1:0] wr_stb,
   input logic [LANES-1:0] oe_lane,
   input logic [2:0]       cyc_type,
   input logic             ref_stb,
   input logic [AW-1:0]    ref_row,
   input logic [AW-1:0]    ref_cnt
);
   p_idle_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd0) |-> (oe_lane == '0));

   p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_stb & wr_stb) == '0));

   p_wr_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb) |-> (cyc_type == 3'd2 || cyc_type == 3'd3));

   p_cbr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd5) |-> (oe_lane == '0 && rd_stb == '0 && wr_stb == '0));

   p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_stb && (cyc_type == 3'd5 || cyc_type == 3'd6)) |-> (ref_cnt == AW'(ref_row + 1'b1)));
endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.AW(ADDR_W), .LANES(LANES)) i_chk (
   .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .oe_lane(oe_lane),
   .cyc_type(cyc_type), .ref_stb(ref_stb), .ref_row(ref_row), .ref_cnt(ref_cnt)
);

// File: tb/test_dram_strobe_decoder.sv
`timescale 1ns/1ps
module test_dram_strobe_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ras_n = 1'b1;
   logic [1:0] cas_n = 2'b11;
   logic       we_n = 1'b1;
   logic       oe_n = 1'b1;
   logic [8:0] addr = '0;
   logic [8:0] row_addr, col_addr, ref_row;
   logic [1:0] rd_stb, wr_stb, oe_lane;
   logic [2:0] cyc_type;
   logic       ref_stb;

   int checks = 0;
   int errors = 0;
   int exp_cnt = 0;
   int n_rd0 = 0, n_rd1 = 0, n_wr0 = 0, n_wr1 = 0, n_ref = 0;
   int ref_last = 0;
   int s_rd0, s_rd1, s_wr0, s_wr1, s_ref;

   always #5 clk = ~clk;

   dram_strobe_decoder i_dram_strobe_decoder (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .row_addr(row_addr), .col_addr(col_addr), .rd_stb(rd_stb),
      .wr_stb(wr_stb), .oe_lane(oe_lane), .cyc_type(cyc_type), .ref_stb(ref_stb),
      .ref_row(ref_row)
   );

   // pulse monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         n_rd0 += int'(rd_stb[0]);
         n_rd1 += int'(rd_stb[1]);
         n_wr0 += int'(wr_stb[0]);
         n_wr1 += int'(wr_stb[1]);
         if (ref_stb) begin
            n_ref++;
            ref_last = int'(ref_row);
         end
      end
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic snap();
      s_rd0 = n_rd0; s_rd1 = n_rd1; s_wr0 = n_wr0; s_wr1 = n_wr1; s_ref = n_ref;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic release_all();
      ras_n = 1'b1; wt(4);
      cas_n = 2'b11; we_n = 1'b1; oe_n = 1'b1; wt(4);
   endtask

   task automatic t_reset();
      chk("R1 reset type", int'(cyc_type), 0);
      chk("R1 reset oe", int'(oe_lane), 0);
      chk("R11 reset ref_row", int'(ref_row), 0);
   endtask

   task automatic t_read_word();
      snap();
      addr = 9'h0A5; ras_n = 1'b0; wt(4);
      addr = 9'h13C; we_n = 1'b1; oe_n = 1'b0; cas_n = 2'b00; wt(4);
      chk("R2 type read", int'(cyc_type), 1);
      chk("R2 row", int'(row_addr), 'h0A5);
      chk("R2 col", int'(col_addr), 'h13C);
      chk("R2 rd lane0", n_rd0 - s_rd0, 1);
      chk("R2 rd lane1", n_rd1 - s_rd1, 1);
      chk("R3 oe word", int'(oe_lane), 3);
      oe_n = 1'b1; wt(4);
      chk("R3 oe off by OE", int'(oe_lane), 0);
      release_all();
      chk("R1 standby type", int'(cyc_type), 0);
      chk("R1 standby oe", int'(oe_lane), 0);
      chk("R8 no refresh after access", n_ref - s_ref, 0);
   endtask

   task automatic t_byte_read_upper();
      snap();
      addr = 9'h1FF; ras_n = 1'b0; wt(4);
      oe_n = 1'b0; cas_n = 2'b01; wt(4);
      chk("R3 oe upper only", int'(oe_lane), 2);
      chk("R3 rd lane0 none", n_rd0 - s_rd0, 0);
      chk("R3 rd lane1", n_rd1 - s_rd1, 1);
      release_all();
   endtask

   task automatic t_early_write();
      snap();
      we_n = 1'b0; oe_n = 1'b0; addr = 9'h044; ras_n = 1'b0; wt(4);
      addr = 9'h0F0; cas_n = 2'b10; wt(4);
      chk("R4 type early write", int'(cyc_type), 2);
      chk("R4 wr lane0", n_wr0 - s_wr0, 1);
      chk("R4 wr lane1 none", n_wr1 - s_wr1, 0);
      chk("R4 oe off", int'(oe_lane), 0);
      chk("R4 no read", (n_rd0 - s_rd0) + (n_rd1 - s_rd1), 0);
      release_all();
   endtask

   task automatic t_late_write();
      snap();
      addr = 9'h101; ras_n = 1'b0; wt(4);
      oe_n = 1'b0; addr = 9'h077; cas_n = 2'b00; wt(4);
      we_n = 1'b0; wt(4);
      chk("R5 type late write", int'(cyc_type), 3);
      chk("R5 wr lane0", n_wr0 - s_wr0, 1);
      chk("R5 wr lane1", n_wr1 - s_wr1, 1);
      chk("R5 oe off", int'(oe_lane), 0);
      release_all();
   endtask

   task automatic t_page();
      snap();
      addr = 9'h033; ras_n = 1'b0; wt(4);
      for (int k = 0; k < 3; k++) begin
         addr = 9'(9'h040 + k * 7); cas_n = 2'b00; wt(4);
         chk("R6 page col", int'(col_addr), 'h040 + k * 7);
         cas_n = 2'b11; wt(4);
      end
      chk("R6 page rd lane0", n_rd0 - s_rd0, 3);
      chk("R6 page rd lane1", n_rd1 - s_rd1, 3);
      chk("R6 page row kept", int'(row_addr), 'h033);
      release_all();
   endtask

   task automatic t_combined();
      snap();
      addr = 9'h0B2; ras_n = 1'b0; wt(4);
      oe_n = 1'b0; addr = 9'h0E1; cas_n = 2'b10; wt(4);
      addr = 9'h155; cas_n = 2'b00; wt(4);
      chk("R7 col from first fall", int'(col_addr), 'h0E1);
      chk("R7 second lane read", n_rd1 - s_rd1, 1);
      cas_n = 2'b01; wt(4);
      chk("R7 upper still enabled", int'(oe_lane), 2);
      ras_n = 1'b1; wt(4);
      chk("R7 cycle held by last lane", int'(cyc_type), 1);
      cas_n = 2'b11; wt(4);
      chk("R7 ends at last rise", int'(cyc_type), 0);
      oe_n = 1'b1; wt(2);
   endtask

   task automatic t_ronly();
      snap();
      addr = 9'h0C7; ras_n = 1'b0; wt(4);
      chk("R8 type row-only", int'(cyc_type), 4);
      chk("R8 row", int'(row_addr), 'h0C7);
      ras_n = 1'b1; wt(4);
      chk("R8 ref pulse", n_ref - s_ref, 1);
      chk("R8 ref row", ref_last, 'h0C7);
      chk("R8 back to standby", int'(cyc_type), 0);
   endtask

   task automatic t_cbr();
      int row_before;
      row_before = int'(row_addr);
      snap();
      we_n = 1'b1; oe_n = 1'b0; addr = 9'h1AB; cas_n = 2'b00; wt(4);
      ras_n = 1'b0; wt(4);
      chk("R9 type cbr", int'(cyc_type), 5);
      chk("R9 row unchanged", int'(row_addr), row_before);
      chk("R9 ref pulse", n_ref - s_ref, 1);
      chk("R9 ref row from counter", ref_last, exp_cnt);
      chk("R9 oe off", int'(oe_lane), 0);
      chk("R9 no access", (n_rd0 - s_rd0) + (n_rd1 - s_rd1) + (n_wr0 - s_wr0) + (n_wr1 - s_wr1), 0);
      exp_cnt = (exp_cnt + 1) % 512;
      release_all();
      chk("R1 standby after cbr", int'(cyc_type), 0);
   endtask

   task automatic t_hidden();
      snap();
      addr = 9'h0D4; ras_n = 1'b0; wt(4);
      oe_n = 1'b0; addr = 9'h012; cas_n = 2'b00; wt(4);
      ras_n = 1'b1; wt(4);
      chk("R10 data held between", int'(oe_lane), 3);
      ras_n = 1'b0; wt(4);
      chk("R10 type hidden", int'(cyc_type), 6);
      chk("R10 data held", int'(oe_lane), 3);
      chk("R10 ref row from counter", ref_last, exp_cnt);
      chk("R10 ref pulse", n_ref - s_ref, 1);
      exp_cnt = (exp_cnt + 1) % 512;
      release_all();
   endtask

   task automatic cbr_quick();
      cas_n = 2'b00; wt(3);
      ras_n = 1'b0; wt(3);
      ras_n = 1'b1; wt(3);
      cas_n = 2'b11; wt(3);
   endtask

   task automatic t_wrap();
      int n;
      n = 512 - exp_cnt;
      snap();
      for (int i = 0; i < n; i++) cbr_quick();
      chk("R11 sweep pulses", n_ref - s_ref, n);
      chk("R11 last row before wrap", ref_last, 511);
      cbr_quick();
      chk("R11 wrapped to zero", ref_last, 0);
      exp_cnt = 1;
   endtask

   initial begin
      wt(3);
      rst_n = 1'b1;
      wt(2);
      t_reset();
      t_read_word();
      t_byte_read_upper();
      t_early_write();
      t_late_write();
      t_page();
      t_combined();
      t_ronly();
      t_cbr();
      t_hidden();
      t_wrap();
      t_cbr();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule